// File: doc/BRIEF.md
# Dual-Channel DDR Sample Deinterleaver

This block sits behind the receive pads of a two-channel data converter link. The link carries one 10-bit word per clock phase on a single parallel bus, so each period of the forwarded clock holds one sample of each channel. The forwarded clock is used directly as the receiving clock. The block takes the word on the bus during the low phase as channel A and the word during the high phase as channel B. It joins each A word with the B word that follows it and presents the two as one aligned pair with one valid strobe.

A small configuration stage reports which output signalling the link is set to use. The default comes from a three-level strap, given here as a two-bit code. A register-style write can replace the strap choice, and a clear input hands control back to the strap. The result is status only: a bit for LVDS versus CMOS signalling and a bit for the reduced LVDS drive current of 2 mA, where the nominal current is 3 mA.

Top module: `ddr_deinterleave`

## Requirements
- R1: A word present on `ddr_data` in the low phase that ends at rising edge k is paired with the word present in the high phase that follows edge k. The pair appears on `chan_a` (low-phase word) and `chan_b` (high-phase word) after rising edge k+1.
- R2: After reset is released, `pair_valid` stays low until a full pair has been captured. The first low-phase word must be sampled at a rising edge with reset low, and its high-phase partner must follow.
- R3: Once raised, `pair_valid` stays high, with a new pair on every clock period, until the next reset.
- R4: With no override active, the status follows `strap_sel` at once. 00 (tied low) gives CMOS. 01 (floating) gives LVDS at 3 mA. 10 (tied high) gives LVDS at 2 mA. 11 is treated like floating.
- R5: A rising edge with `cfg_wr` high and `cfg_clr` low installs `cfg_mode` as an override from the next cycle on. The codes are the same as for `strap_sel`, with 11 giving LVDS at 3 mA. While the override holds, changes on `strap_sel` have no effect on the status.
- R6: A rising edge with `cfg_clr` high removes the override, even if `cfg_wr` is also high. The status then follows the strap again.
- R7: `mode_lvds` is 1 for either LVDS setting. `mode_low_drive` is 1 only for LVDS at 2 mA, so it is 0 in CMOS mode.
- R8: A rising edge with `rst` high clears `chan_a`, `chan_b`, `pair_valid` and the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded output clock, used as the receiving clock |
| rst | input | 1 | Synchronous active-high reset |
| ddr_data | input | 10 | Double-data-rate data bus carrying both channels |
| strap_sel | input | 2 | Encoded three-level mode strap |
| cfg_wr | input | 1 | Mode override write strobe |
| cfg_mode | input | 2 | Mode code written on `cfg_wr` |
| cfg_clr | input | 1 | Override clear, hands control back to the strap |
| chan_a | output | 10 | Channel A sample of the current pair |
| chan_b | output | 10 | Channel B sample of the current pair |
| pair_valid | output | 1 | High for each period in which a captured pair is presented |
| mode_lvds | output | 1 | 1 for LVDS signalling, 0 for CMOS |
| mode_low_drive | output | 1 | 1 for the reduced LVDS drive current |
| mode_override | output | 1 | 1 while a written mode replaces the strap |

## Verification
The data path is driven with several patterns. Random words catch general mispairing. Opposite constant values on the two phases (all ones against all zeros) show at once if the channels are swapped. An incrementing sequence with the B word one above the A word shows an off-by-one-period pairing, where A is joined to the wrong neighbour. A reset in the middle of the stream checks that the strobe waits for a fresh full pair. On the mode side, all four strap codes and all four write codes are applied. The strap is also moved while an override is held, and a clear is applied on the same edge as a write, which separates the strap path from the override path and shows which of the two inputs wins.

// File: rtl/ddr_deint_pkg.sv
package ddr_deint_pkg;

    typedef enum logic [1:0] {
        SIG_CMOS    = 2'b00,
        SIG_LVDS_HI = 2'b01,
        SIG_LVDS_LO = 2'b10
    } sig_mode_t;

    localparam int CODE_W = 2;

    function automatic sig_mode_t code_to_mode(input logic [CODE_W-1:0] code);
        case (code)
            2'b00:   return SIG_CMOS;
            2'b10:   return SIG_LVDS_LO;
            default: return SIG_LVDS_HI;
        endcase
    endfunction

    function automatic logic mode_is_lvds(input sig_mode_t m);
        return m != SIG_CMOS;
    endfunction

    function automatic logic mode_is_low_drive(input sig_mode_t m);
        return m == SIG_LVDS_LO;
    endfunction

endpackage

// File: rtl/ddr_phase_capture.sv
module ddr_phase_capture #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] low_word,
    output logic [W-1:0] high_word,
    output logic         low_seen,
    output logic         high_seen
);
    // Low-phase word is taken at the rising edge that ends the low phase.
    always_ff @(posedge clk) begin
        if (rst) begin
            low_word <= '0;
            low_seen <= 1'b0;
        end else begin
            low_word <= din;
            low_seen <= 1'b1;
        end
    end

    // High-phase word is taken at the falling edge that ends the high phase.
    always_ff @(negedge clk) begin
        if (rst) begin
            high_word <= '0;
            high_seen <= 1'b0;
        end else begin
            high_word <= din;
            high_seen <= low_seen;
        end
    end

    // R2: a partner word may only be flagged after a low-phase word exists
    a_r2_high_after_low: assert property (@(negedge clk) disable iff (rst)
        high_seen |-> low_seen);
endmodule

// File: rtl/ddr_pair_register.sv
module ddr_pair_register #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] low_word,
    input  logic [W-1:0] high_word,
    input  logic         pair_ready,
    output logic [W-1:0] out_a,
    output logic [W-1:0] out_b,
    output logic         out_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_a     <= '0;
            out_b     <= '0;
            out_valid <= 1'b0;
        end else if (pair_ready) begin
            out_a     <= low_word;
            out_b     <= high_word;
            out_valid <= 1'b1;
        end else begin
            out_valid <= 1'b0;
        end
    end

    // R3: the strobe never drops between resets
    a_r3_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);
endmodule

// File: rtl/ddr_mode_resolve.sv
module ddr_mode_resolve
    import ddr_deint_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] strap_code,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              clr,
    output sig_mode_t         mode,
    output logic              ovr_on
);
    sig_mode_t ovr_mode;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ovr_on   <= 1'b0;
            ovr_mode <= SIG_CMOS;
        end else if (wr_en) begin
            ovr_on   <= 1'b1;
            ovr_mode <= code_to_mode(wr_code);
        end
    end

    always_comb begin
        mode = ovr_on ? ovr_mode : code_to_mode(strap_code);
    end

    // R6: a clear always leaves the strap in control
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> !ovr_on);
endmodule

// File: rtl/ddr_deinterleave.sv
module ddr_deinterleave
    import ddr_deint_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] ddr_data,
    input  logic [CODE_W-1:0] strap_sel,
    input  logic              cfg_wr,
    input  logic [CODE_W-1:0] cfg_mode,
    input  logic              cfg_clr,
    output logic [DATA_W-1:0] chan_a,
    output logic [DATA_W-1:0] chan_b,
    output logic              pair_valid,
    output logic              mode_lvds,
    output logic              mode_low_drive,
    output logic              mode_override
);
    logic [DATA_W-1:0] low_word;
    logic [DATA_W-1:0] high_word;
    logic              low_seen;
    logic              high_seen;
    sig_mode_t         cur_mode;

    ddr_phase_capture #(.W(DATA_W)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .din       (ddr_data),
        .low_word  (low_word),
        .high_word (high_word),
        .low_seen  (low_seen),
        .high_seen (high_seen)
    );

    ddr_pair_register #(.W(DATA_W)) u_pair (
        .clk        (clk),
        .rst        (rst),
        .low_word   (low_word),
        .high_word  (high_word),
        .pair_ready (high_seen),
        .out_a      (chan_a),
        .out_b      (chan_b),
        .out_valid  (pair_valid)
    );

    ddr_mode_resolve u_mode (
        .clk        (clk),
        .rst        (rst),
        .strap_code (strap_sel),
        .wr_en      (cfg_wr),
        .wr_code    (cfg_mode),
        .clr        (cfg_clr),
        .mode       (cur_mode),
        .ovr_on     (mode_override)
    );

    assign mode_lvds      = mode_is_lvds(cur_mode);
    assign mode_low_drive = mode_is_low_drive(cur_mode);

    // R2: a presented pair implies a low-phase word has been captured
    a_r2_valid_needs_capture: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> low_seen);

    // R5: an accepted write turns the override on
    a_r5_write_installs: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_wr) && !$past(cfg_clr) && !$past(rst)) |-> mode_override);

    // R5: a held override ignores the strap
    a_r5_strap_ignored: assert property (@(posedge clk) disable iff (rst)
        (mode_override && $past(mode_override) && !$past(cfg_wr) && !$past(rst))
            |-> ($stable(mode_lvds) && $stable(mode_low_drive)));

    // R7: reduced drive only exists with LVDS signalling
    a_r7_low_drive_lvds: assert property (@(posedge clk) disable iff (rst)
        mode_low_drive |-> mode_lvds);

    // R8: reset leaves no pair and no override
    a_r8_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!pair_valid && !mode_override && chan_a == '0));
endmodule

// File: tb/sim_ddr_deinterleave.sv
`timescale 1ns/1ps
module sim_ddr_deinterleave;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] ddr_data = '0;
    logic [1:0] strap_sel = 2'b00;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic       cfg_clr = 1'b0;
    logic [9:0] chan_a, chan_b;
    logic       pair_valid, mode_lvds, mode_low_drive, mode_override;

    int checks = 0;
    int failures = 0;

    ddr_deinterleave u0 (
        .clk(clk), .rst(rst), .ddr_data(ddr_data), .strap_sel(strap_sel),
        .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_clr(cfg_clr),
        .chan_a(chan_a), .chan_b(chan_b), .pair_valid(pair_valid),
        .mode_lvds(mode_lvds), .mode_low_drive(mode_low_drive),
        .mode_override(mode_override)
    );

    always #5 clk = ~clk;

    // model state
    int   exp_a = 0, exp_b = 0;
    bit   exp_v = 0;
    int   pend_a = 0;
    bit   pend_ok = 0;
    bit   ovr = 0;
    int   ovr_code = 0;
    bit   rst_q = 1, wr_q = 0, clr_q = 0;
    int   wr_code_q = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // mode code: 0 CMOS, 1 LVDS 3 mA, 2 LVDS 2 mA, 3 behaves like 1
    function automatic int lvds_of(input int code);
        return (code == 0) ? 0 : 1;
    endfunction
    function automatic int low_of(input int code);
        return (code == 2) ? 1 : 0;
    endfunction

    // one clock period of stimulus; pattern selects the data words
    task automatic period(input bit r, input int pat, input int idx,
                          input int strap, input bit wr, input int wcode, input bit clr);
        int eff;
        int bw, aw;
        bit prev_clr;
        @(posedge clk);
        #1;
        prev_clr = clr_q;
        if (rst_q || clr_q) ovr = 0;
        else if (wr_q) begin ovr = 1; ovr_code = wr_code_q; end
        if (rst_q) begin
            check("R8 valid after reset", pair_valid, 0);
            check("R8 chan_a after reset", chan_a, 0);
            check("R8 override after reset", mode_override, 0);
        end else begin
            if (exp_v) begin
                check("R3 pair_valid held", pair_valid, 1);
                check("R1 chan_a", chan_a, exp_a);
                check("R1 chan_b", chan_b, exp_b);
            end else begin
                check("R2 pair_valid early", pair_valid, 0);
            end
            eff = ovr ? ovr_code : int'(strap_sel);
            if (prev_clr)
                check("R6 override cleared", mode_override, 0);
            else
                check(ovr ? "R5 override flag" : "R4 override flag", mode_override, ovr);
            check(ovr ? "R5 mode_lvds" : "R4 mode_lvds", mode_lvds, lvds_of(eff));
            check("R7 mode_low_drive", mode_low_drive, low_of(eff));
        end
        rst_q = r; wr_q = wr; clr_q = clr; wr_code_q = wcode;
        rst <= r; cfg_wr <= wr; cfg_clr <= clr; cfg_mode <= 2'(wcode);
        #1.5;
        case (pat)
            0: begin bw = $urandom_range(0, 1023); aw = $urandom_range(0, 1023); end
            1: begin bw = 0; aw = 1023; end
            default: begin aw = (idx * 2) & 1023; bw = (pend_a + 1) & 1023; end
        endcase
        ddr_data <= 10'(bw);
        strap_sel <= 2'(strap);
        if (r) begin exp_a = 0; exp_b = 0; exp_v = 0; end
        else if (pend_ok) begin exp_a = pend_a; exp_b = bw; exp_v = 1; end
        #5;
        ddr_data <= 10'(aw);
        pend_a = aw;
        pend_ok = !r;
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL R3 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) period(1, 0, i, 0, 0, 0, 0);
        // R2/R1: random data, strap sweep (R4 incl. code 3)
        for (int i = 0; i < 20; i++) period(0, 0, i, i % 4, 0, 0, 0);
        // R1: opposite constants reveal channel swap
        for (int i = 0; i < 6; i++) period(0, 1, i, 2, 0, 0, 0);
        // R1: incrementing pattern reveals pairing offset
        for (int i = 0; i < 10; i++) period(0, 2, i, 1, 0, 0, 0);
        // R8 then R2: mid-stream reset
        period(1, 0, 0, 1, 0, 0, 0);
        period(1, 0, 0, 1, 0, 0, 0);
        for (int i = 0; i < 5; i++) period(0, 0, i, 0, 0, 0, 0);
        // R5: each write code, strap moved while override held
        for (int c = 0; c < 4; c++) begin
            period(0, 0, c, 0, 1, c, 0);
            for (int s = 0; s < 4; s++) period(0, 0, s, s, 0, 0, 0);
        end
        // R6: clear returns to strap
        period(0, 0, 0, 2, 0, 0, 1);
        period(0, 0, 0, 2, 0, 0, 0);
        period(0, 0, 0, 0, 0, 0, 0);
        // R6: clear and write on the same edge
        period(0, 0, 0, 1, 1, 2, 0);
        period(0, 0, 0, 1, 1, 0, 1);
        period(0, 0, 0, 0, 0, 0, 0);
        period(0, 0, 0, 2, 0, 0, 0);
        // R5: overwrite one override with another
        period(0, 0, 0, 0, 1, 1, 0);
        period(0, 0, 0, 0, 1, 2, 0);
        period(0, 0, 0, 0, 0, 0, 0);
        period(0, 0, 0, 3, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule